// File: doc/BRIEF.md
# Linked-Page Transmit Walker

The walker pulls outgoing messages from a host buffer split into fixed-size pages. Software places variable-length records one after another in a page and reports each new message by writing a doorbell. The walker keeps a count of unserved doorbells. While that count is nonzero, it reads the next record header through a simple read port. A normal record is streamed downstream word by word, with start and end markers.

A record whose type field holds the link code ends the current page. The walker takes the 64-bit address held in the record and continues the walk there. It also emits a one-cycle event so that software can reclaim the page it has just left.

The walk begins at an address loaded through low and high configuration strobes. Two control flags gate the walker: hold and unconfigured. Each flag is set and cleared through separate strobes. A malformed header stops the walker with a sticky error until hold is applied.

Top module: `tx_page_walker`

## Requirements
- R1: After reset, hold and unconfigured are both set, and rd_req_valid, tx_valid, link_evt and walk_err are all low.
- R2: A doorbell write increments the outstanding count only if cfg_wdata equals exactly 1 and hold is clear. Any other value has no effect. The walker fetches a header only when hold and unconfigured are both clear and the count is nonzero.
- R3: A header word carries the record size in bytes in bits 15:0 and the record type in bits 31:16. A normal record is forwarded as ceil(size/4) words in ascending address order, starting with the header word. tx_sop is high on the first word and tx_eop on the last.
- R4: The next record starts at the record address plus the size rounded up to a multiple of 4.
- R5: Each fully forwarded record decrements the count. The walker issues no read while the count is zero.
- R6: A record of type 0x1001 is a link. The word at record+4 is the low half of the next address and the word at record+8 is the high half. The walker resumes at that 64-bit address, forwards nothing for the link and leaves the count unchanged.
- R7: Every consumed link produces exactly one single-cycle pulse on link_evt.
- R8: A header with a size below 4, or whose page offset plus size exceeds the 2048-byte page, sets walk_err. walk_err stays set, and no further read or transmit takes place, while hold is clear.
- R9: While hold is set, walk_err and the count are cleared, the walker idles, and the read pointer reloads from the base address registers.
- R10: cfg_wdata bit 0 is the hold flag and bit 1 is the unconfigured flag. The set strobe sets the flags whose bits are 1, and the clear strobe clears the flags whose bits are 1.
- R11: rd_req_valid stays high with a stable, word-aligned rd_req_addr until rd_req_ready is high. Only one read is in flight, and its data is taken in the cycle rd_rsp_valid is high.
- R12: While tx_valid is high and tx_ready is low, tx_valid, tx_data, tx_sop and tx_eop hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wdata | input | 32 | Write data shared by all configuration strobes and the doorbell |
| cfg_base_lo_we | input | 1 | Load the low 32 bits of the base address |
| cfg_base_hi_we | input | 1 | Load the high 32 bits of the base address |
| cfg_ctl_set_we | input | 1 | Set the control flags selected in cfg_wdata |
| cfg_ctl_clr_we | input | 1 | Clear the control flags selected in cfg_wdata |
| db_we | input | 1 | Doorbell write |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data, little-endian word |
| tx_valid | output | 1 | Downstream word valid |
| tx_ready | input | 1 | Downstream ready |
| tx_data | output | 32 | Downstream message word |
| tx_sop | output | 1 | First word of a message |
| tx_eop | output | 1 | Last word of a message |
| link_evt | output | 1 | One-cycle pulse per consumed link record |
| walk_err | output | 1 | Sticky malformed-record flag |

## Verification
A doorbell reaches the count one clock after its write, and the header request appears one clock after that. Each read result moves to tx_data one clock after the response cycle. link_evt rises one clock after the response that carries the high half of the address. Because memory latency and both ready signals are randomised, the bench does not check at fixed cycles. It records every handshake at the falling edge following the rising edge where it took place, and compares the handshakes in order against a queue of expected words. Absence checks (ignored doorbells, unconfigured, count at zero, error halt) watch a 20-cycle window, which is several times longer than the two-clock path from doorbell to request.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  typedef enum logic [3:0] {
    WS_IDLE,   // waiting for run and a pending doorbell
    WS_HREQ,   // header read request
    WS_HWAIT,  // header read response
    WS_SEND,   // present one message word downstream
    WS_DREQ,   // payload read request
    WS_DWAIT,  // payload read response
    WS_LREQ,   // link low-word request
    WS_LWAIT,  // link low-word response
    WS_UREQ,   // link high-word request
    WS_UWAIT,  // link high-word response
    WS_ERR     // malformed record, parked until hold
  } walk_st_e;

  localparam int WORD_BYTES = 4;
  localparam int MIN_REC_BYTES = 4;
endpackage

// File: rtl/tpw_ctl.sv
module tpw_ctl #(
  parameter int ADDR_W     = 64,
  parameter int CNT_W      = 8,
  parameter int HOLD_BIT   = 0,
  parameter int UNCONF_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_base_lo_we,
  input  logic              cfg_base_hi_we,
  input  logic              cfg_ctl_set_we,
  input  logic              cfg_ctl_clr_we,
  input  logic              db_we,
  input  logic              msg_done,
  output logic              hold,
  output logic              run,
  output logic              pend_nz,
  output logic [ADDR_W-1:0] base_addr
);
  localparam int HI_W = ADDR_W - 32;

  logic             hold_q, hold_d, unconf_q, unconf_d;
  logic [31:0]      base_lo_q, base_lo_d;
  logic [HI_W-1:0]  base_hi_q, base_hi_d;
  logic [CNT_W-1:0] pend_q, pend_d;
  logic             inc, dec;

  always_comb begin
    hold_d    = hold_q;
    unconf_d  = unconf_q;
    base_lo_d = base_lo_q;
    base_hi_d = base_hi_q;
    if (cfg_ctl_set_we) begin
      hold_d   = hold_d   | cfg_wdata[HOLD_BIT];
      unconf_d = unconf_d | cfg_wdata[UNCONF_BIT];
    end
    if (cfg_ctl_clr_we) begin
      hold_d   = hold_d   & ~cfg_wdata[HOLD_BIT];
      unconf_d = unconf_d & ~cfg_wdata[UNCONF_BIT];
    end
    if (cfg_base_lo_we) base_lo_d = cfg_wdata;
    if (cfg_base_hi_we) base_hi_d = cfg_wdata[HI_W-1:0];

    inc = db_we && (cfg_wdata == 32'd1) && !hold_q && (pend_q != {CNT_W{1'b1}});
    dec = msg_done;
    pend_d = pend_q;
    if (hold_q)            pend_d = '0;
    else if (inc && !dec)  pend_d = pend_q + CNT_W'(1);
    else if (dec && !inc)  pend_d = pend_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b1;
      unconf_q  <= 1'b1;
      base_lo_q <= '0;
      base_hi_q <= '0;
      pend_q    <= '0;
    end else begin
      hold_q    <= hold_d;
      unconf_q  <= unconf_d;
      base_lo_q <= base_lo_d;
      base_hi_q <= base_hi_d;
      pend_q    <= pend_d;
    end
  end

  assign hold      = hold_q;
  assign run       = !hold_q && !unconf_q;
  assign pend_nz   = (pend_q != '0);
  assign base_addr = {base_hi_q, base_lo_q};

  // R5: the walker never completes a message the count does not cover
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> (pend_q != '0));
  // R9: hold empties the outstanding count
  a_r9_hold_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (pend_q == '0));
endmodule

// File: rtl/tpw_fsm.sv
module tpw_fsm
  import tpw_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          PAGE_BYTES = 2048,
  parameter logic [15:0] LINK_TYPE  = 16'h1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              run,
  input  logic              pend_nz,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              msg_done,
  output logic              link_evt,
  output logic              walk_err
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int SUM_W = 17;
  localparam int LW = 15;

  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [31:0]       word_q, word_d, lo_q, lo_d;
  logic [LW-1:0]     left_q, left_d;
  logic              first_q, first_d, err_q, err_d, link_q, link_d;

  logic [15:0]       hdr_size, hdr_type;
  logic [SUM_W-1:0]  off_sum;
  logic [LW-1:0]     hdr_words;
  logic              hdr_bad;

  always_comb begin
    hdr_size  = rd_rsp_data[15:0];
    hdr_type  = rd_rsp_data[31:16];
    off_sum   = SUM_W'(ptr_q[PG_W-1:0]) + SUM_W'(hdr_size);
    hdr_words = LW'((SUM_W'(hdr_size) + SUM_W'(WORD_BYTES - 1)) >> 2);
    hdr_bad   = (hdr_size < 16'(MIN_REC_BYTES)) || (off_sum > SUM_W'(PAGE_BYTES));
  end

  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    word_d   = word_q;
    lo_d     = lo_q;
    left_d   = left_q;
    first_d  = first_q;
    err_d    = err_q;
    link_d   = 1'b0;
    msg_done = 1'b0;
    if (hold) begin
      st_d  = WS_IDLE;
      ptr_d = base_addr;
      err_d = 1'b0;
    end else begin
      unique case (st_q)
        WS_IDLE:  if (run && pend_nz) st_d = WS_HREQ;
        WS_HREQ:  if (rd_req_ready) st_d = WS_HWAIT;
        WS_HWAIT: if (rd_rsp_valid) begin
          if (hdr_bad) begin
            err_d = 1'b1;
            st_d  = WS_ERR;
          end else if (hdr_type == LINK_TYPE) begin
            ptr_d = ptr_q + ADDR_W'(WORD_BYTES);
            st_d  = WS_LREQ;
          end else begin
            word_d  = rd_rsp_data;
            left_d  = hdr_words;
            first_d = 1'b1;
            st_d    = WS_SEND;
          end
        end
        WS_SEND: if (tx_ready) begin
          ptr_d   = ptr_q + ADDR_W'(WORD_BYTES);
          first_d = 1'b0;
          left_d  = left_q - LW'(1);
          if (left_q == LW'(1)) begin
            msg_done = 1'b1;
            st_d     = WS_IDLE;
          end else begin
            st_d = WS_DREQ;
          end
        end
        WS_DREQ:  if (rd_req_ready) st_d = WS_DWAIT;
        WS_DWAIT: if (rd_rsp_valid) begin
          word_d = rd_rsp_data;
          st_d   = WS_SEND;
        end
        WS_LREQ:  if (rd_req_ready) st_d = WS_LWAIT;
        WS_LWAIT: if (rd_rsp_valid) begin
          lo_d  = rd_rsp_data;
          ptr_d = ptr_q + ADDR_W'(WORD_BYTES);
          st_d  = WS_UREQ;
        end
        WS_UREQ:  if (rd_req_ready) st_d = WS_UWAIT;
        WS_UWAIT: if (rd_rsp_valid) begin
          ptr_d  = ADDR_W'({rd_rsp_data, lo_q});
          link_d = 1'b1;
          st_d   = WS_IDLE;
        end
        WS_ERR:   st_d = WS_ERR;
        default:  st_d = WS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      ptr_q   <= '0;
      word_q  <= '0;
      lo_q    <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      link_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      word_q  <= word_d;
      lo_q    <= lo_d;
      left_q  <= left_d;
      first_q <= first_d;
      err_q   <= err_d;
      link_q  <= link_d;
    end
  end

  assign rd_req_valid = (st_q == WS_HREQ) || (st_q == WS_DREQ) ||
                        (st_q == WS_LREQ) || (st_q == WS_UREQ);
  assign rd_req_addr  = ptr_q;
  assign tx_valid     = (st_q == WS_SEND);
  assign tx_data      = word_q;
  assign tx_sop       = first_q;
  assign tx_eop       = (left_q == LW'(1));
  assign link_evt     = link_q;
  assign walk_err     = err_q;

  // R11: a pending read keeps its address until accepted
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && !hold) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R12: a stalled word is held unchanged
  a_r12_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !hold) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));
  // R8: error is sticky and silences both ports
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_err && !hold) |=> walk_err);
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    walk_err |-> (!rd_req_valid && !tx_valid));
  // R7: link event lasts a single cycle
  a_r7_link_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> !link_evt);
endmodule

// File: rtl/tx_page_walker.sv
module tx_page_walker #(
  parameter int          ADDR_W     = 64,
  parameter int          CNT_W      = 8,
  parameter int          PAGE_BYTES = 2048,
  parameter logic [15:0] LINK_TYPE  = 16'h1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_base_lo_we,
  input  logic              cfg_base_hi_we,
  input  logic              cfg_ctl_set_we,
  input  logic              cfg_ctl_clr_we,
  input  logic              db_we,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              link_evt,
  output logic              walk_err
);
  logic [1:0]        rsync_q;
  logic              rst_ns;
  logic              hold, run, pend_nz, msg_done;
  logic [ADDR_W-1:0] base_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  tpw_ctl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HOLD_BIT(0), .UNCONF_BIT(1)
  ) u_ctl (
    .clk(clk), .rst_n(rst_ns), .cfg_wdata(cfg_wdata),
    .cfg_base_lo_we(cfg_base_lo_we), .cfg_base_hi_we(cfg_base_hi_we),
    .cfg_ctl_set_we(cfg_ctl_set_we), .cfg_ctl_clr_we(cfg_ctl_clr_we),
    .db_we(db_we), .msg_done(msg_done), .hold(hold), .run(run),
    .pend_nz(pend_nz), .base_addr(base_addr)
  );

  tpw_fsm #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .LINK_TYPE(LINK_TYPE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_ns), .hold(hold), .run(run), .pend_nz(pend_nz),
    .base_addr(base_addr), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .msg_done(msg_done), .link_evt(link_evt), .walk_err(walk_err)
  );
endmodule

// File: tb/tb_tx_page_walker.sv
`timescale 1ns/1ps
module tb_tx_page_walker;
  localparam logic [63:0] REGION = 64'h0000_0002_ABCD_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_wdata;
  logic        cfg_base_lo_we, cfg_base_hi_we, cfg_ctl_set_we, cfg_ctl_clr_we, db_we;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [63:0] rd_req_addr;
  logic [31:0] rd_rsp_data, tx_data;
  logic        tx_valid, tx_ready, tx_sop, tx_eop, link_evt, walk_err;

  always #2.5 clk = ~clk;

  tx_page_walker dut (
    .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata),
    .cfg_base_lo_we(cfg_base_lo_we), .cfg_base_hi_we(cfg_base_hi_we),
    .cfg_ctl_set_we(cfg_ctl_set_we), .cfg_ctl_clr_we(cfg_ctl_clr_we), .db_we(db_we),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .link_evt(link_evt), .walk_err(walk_err)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] exp_d[$];
  bit          exp_s[$];
  bit          exp_e[$];
  int n_chk = 0, n_err = 0;
  int req_seen = 0, links_seen = 0, links_exp = 0, sw_off = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // software model: place one record, inserting a link when the page is full
  task automatic append(input int size);
    int pg_start, nw, other;
    logic [63:0] tgt;
    logic [31:0] v;
    pg_start = sw_off - (sw_off % 2048);
    nw = (size + 3) / 4;
    if (sw_off + 4 * nw > pg_start + 2048 - 12) begin
      other = (pg_start == 0) ? 2048 : 0;
      tgt = REGION + 64'(other);
      mem[sw_off/4]     = {16'h1001, 16'd12};
      mem[sw_off/4 + 1] = tgt[31:0];
      mem[sw_off/4 + 2] = tgt[63:32];
      sw_off = other;
      links_exp++;
    end
    for (int w = 0; w < nw; w++) begin
      if (w == 0) v = {16'h0100 | 16'($urandom % 256), 16'(size)};
      else        v = $urandom;
      mem[sw_off/4 + w] = v;
      exp_d.push_back(v);
      exp_s.push_back(w == 0);
      exp_e.push_back(w == nw - 1);
    end
    sw_off = sw_off + 4 * nw;
  endtask

  task automatic pulse(input int which, input logic [31:0] v);
    @(negedge clk);
    cfg_wdata = v;
    case (which)
      0: cfg_base_lo_we = 1'b1;
      1: cfg_base_hi_we = 1'b1;
      2: cfg_ctl_set_we = 1'b1;
      3: cfg_ctl_clr_we = 1'b1;
      default: db_we = 1'b1;
    endcase
    @(negedge clk);
    cfg_base_lo_we = 1'b0; cfg_base_hi_we = 1'b0;
    cfg_ctl_set_we = 1'b0; cfg_ctl_clr_we = 1'b0; db_we = 1'b0;
  endtask

  task automatic set_base(input logic [63:0] a);
    pulse(0, a[31:0]);
    pulse(1, a[63:32]);
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string what);
    int t;
    t = 0;
    while (exp_d.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    quiet(2);
    chk(exp_d.size() == 0, what, exp_d.size(), 0);
  endtask

  // memory responder, back-pressure and stream monitor
  initial begin : responder
    bit acc_prev, tx_prev, s_prev, e_prev, have, es, ee;
    logic [63:0] a_prev, a_hold;
    logic [31:0] d_prev, ed;
    int wcnt;
    acc_prev = 0; tx_prev = 0; have = 0; wcnt = 0;
    a_prev = '0; a_hold = '0; d_prev = '0; s_prev = 0; e_prev = 0;
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0; tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      if (acc_prev) begin
        req_seen++;
        chk(a_prev[63:12] == REGION[63:12] && a_prev[1:0] == 2'b00,
            "R11 read address in region and aligned", a_prev, REGION);
        have = 1; a_hold = a_prev; wcnt = $urandom % 3;
      end
      if (have) begin
        if (wcnt == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data = mem[a_hold[11:2]];
          have = 0;
        end else wcnt--;
      end
      if (tx_prev) begin
        if (exp_d.size() == 0) chk(0, "R3 R5 unexpected word", d_prev, 0);
        else begin
          ed = exp_d.pop_front(); es = exp_s.pop_front(); ee = exp_e.pop_front();
          chk(d_prev == ed, "R3 R4 R6 R12 word", d_prev, ed);
          chk(s_prev == es, "R3 start marker", s_prev, es);
          chk(e_prev == ee, "R3 end marker", e_prev, ee);
        end
      end
      if (link_evt) links_seen++;
      rd_req_ready = ($urandom % 4) != 0;
      tx_ready = ($urandom % 10) < 7;
      acc_prev = rd_req_valid && rd_req_ready;
      a_prev = rd_req_addr;
      tx_prev = tx_valid && tx_ready;
      d_prev = tx_data; s_prev = tx_sop; e_prev = tx_eop;
    end
  end

  initial begin : watchdog
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    int r, nmsg;
    void'($urandom(32'd91577));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    rst_n = 1'b0; cfg_wdata = '0;
    cfg_base_lo_we = 0; cfg_base_hi_we = 0; cfg_ctl_set_we = 0; cfg_ctl_clr_we = 0; db_we = 0;
    quiet(4);
    rst_n = 1'b1;
    quiet(4);
    chk(!rd_req_valid, "R1 no read after reset", rd_req_valid, 0);
    chk(!tx_valid, "R1 no transmit after reset", tx_valid, 0);
    chk(!walk_err, "R1 error clear after reset", walk_err, 0);
    chk(!link_evt, "R1 no link event after reset", link_evt, 0);

    set_base(REGION);
    pulse(3, 32'h1);                // clear hold only
    sw_off = 0;
    append(5);
    pulse(4, 32'd1);
    quiet(20);
    chk(req_seen == 0, "R2 R10 unconfigured flag blocks walk", req_seen, 0);
    pulse(3, 32'h2);                // clear unconfigured
    drain("R2 R3 R4 first message after configuration");

    r = req_seen;
    append(4);
    pulse(4, 32'd2);
    pulse(4, 32'd0);
    quiet(20);
    chk(req_seen == r, "R2 doorbell value other than 1 ignored", req_seen, r);
    chk(exp_d.size() == 1, "R2 message still queued", exp_d.size(), 1);
    pulse(4, 32'd1);
    drain("R2 R3 single-word record");

    for (int b = 0; b < 7; b++) begin
      nmsg = 10 + ($urandom % 11);
      for (int m = 0; m < nmsg; m++) begin
        append((m == 0) ? 4 : 4 + ($urandom % 77));
        pulse(4, 32'd1);
        quiet($urandom % 3);
      end
      drain("R5 R6 batch drained");
      chk(links_seen == links_exp, "R6 R7 link event count", links_seen, links_exp);
      r = req_seen;
      quiet(20);
      chk(req_seen == r, "R5 no read with zero count", req_seen, r);
    end
    chk(links_exp >= 2, "R6 both page transitions exercised", links_exp, 2);

    pulse(2, 32'h1);                // hold
    set_base(REGION + 64'h7F8);
    mem[2040/4] = {16'h0120, 16'd16};
    pulse(3, 32'h1);
    pulse(4, 32'd1);
    quiet(20);
    chk(walk_err, "R8 record past page end sets error", walk_err, 1);
    chk(!rd_req_valid && !tx_valid, "R8 walker halted", {rd_req_valid, tx_valid}, 0);
    pulse(2, 32'h1);
    quiet(3);
    chk(!walk_err, "R9 R10 hold clears error", walk_err, 0);

    set_base(REGION);
    mem[0] = {16'h0120, 16'd2};
    pulse(3, 32'h1);
    pulse(4, 32'd1);
    quiet(20);
    chk(walk_err, "R8 size below 4 sets error", walk_err, 1);
    pulse(2, 32'h1);
    quiet(3);
    chk(!walk_err, "R9 hold clears error again", walk_err, 0);

    sw_off = 0;
    append(12);
    pulse(3, 32'h1);
    r = req_seen;
    quiet(20);
    chk(req_seen == r, "R9 hold cleared outstanding count", req_seen, r);
    pulse(4, 32'd1);
    drain("R9 walk restarts at programmed base");
    chk(links_seen == links_exp, "R7 no spurious link event", links_seen, links_exp);
    finish_run();
  end
endmodule